// File: doc/BRIEF.md
# Multi-Source Configurable I/O Port

This block is an eight-pin general-purpose I/O port for a microcontroller-based programmable system. Each pin is set up on its own. A per-pin output selector drives the pad from one of four places: a CPU-written output register bit, a bit of an address byte held by a transparent latch, a programmable-logic macrocell output, or an external chip-select line. Each pin's output enable comes either from a CPU-written direction bit or from a macrocell enable term. A static two-bit source code and a static enable-source bit per pin are inputs to the block.

The CPU uses a small register bus. It writes the output, direction and select-control registers. It reads back one source at a time through a registered read selector: the synchronized pin levels, the output register, the direction register, the select-control register or the macrocell outputs. Pads are modelled as separate out, oe and in vectors. The pad outputs are registered, so they follow their sources one clock later.

Top module: `gpio_mux_port`

## Requirements
- R1: Synchronous reset clears the output, direction and select-control registers, the pad output enables, the pad outputs and the read data, so every pin starts as an input whose source is the output register.
- R2: A write strobe loads the output register at address 1, the direction register at address 2 and the select-control register at address 3. Read data is registered and shows the addressed register one clock after the address is presented.
- R3: Address 0 reads the pad inputs through a two-flop synchronizer. A pad change appears on the read data on the third clock edge and not before it. Writes to address 0 change no register.
- R4: With its select-control bit at 0 a pin drives its output register bit. With the bit at 1 it drives the source named by its static code (0 output register, 1 latched address bit, 2 macrocell output, 3 chip-select line). The pad output follows one clock later.
- R5: While address latch enable is high the address source follows the address input. Once the enable goes low it holds the value present on the last clock edge at which the enable was high.
- R6: When a pin's static enable-source bit is 1 its pad output enable follows the macrocell enable term. Otherwise it follows the direction bit, where 1 means drive. The pad enable follows one clock later.
- R7: Address 4 reads the macrocell outputs. Addresses 5 to 7 read zero. Writes to addresses 4 to 7 change no register.
- R8: The pin-level read at address 0 returns the external pad level whatever the direction and output register hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ale | input | 1 | Address latch enable |
| addr_in | input | 8 | Address byte feeding the latch |
| mc_out | input | 8 | Macrocell outputs |
| mc_oe | input | 8 | Macrocell output-enable terms |
| cs_in | input | 8 | External chip-select lines, one per pin |
| cfg_sel | input | 16 | Static 2-bit source code per pin, pin i at bits 2i+1:2i |
| cfg_oe_mc | input | 8 | Static per-pin choice of enable source (1 = macrocell term) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The bench goes after the address latch closing edge. A design that samples the address after the enable falls, rather than keeping the last value seen while it was high, drives the second address byte onto the pins. It counts synchronizer stages by reading the pin level on the second and the third edge after a change: a missing stage shows the new level one edge early. Writes aimed at the read-only and unmapped addresses must leave every register intact, and the macrocell readback must not echo write data. Random per-pin source codes, control bits and enable choices are compared against a bench model, so a swapped source code or an inverted enable choice shows up as a wrong pad bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    SRC_DATA  = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_MACRO = 2'd2,
    SRC_CSEL  = 2'd3
  } src_e;

  localparam logic [REG_AW-1:0] RA_PIN   = 3'd0;
  localparam logic [REG_AW-1:0] RA_DOUT  = 3'd1;
  localparam logic [REG_AW-1:0] RA_DIR   = 3'd2;
  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd3;
  localparam logic [REG_AW-1:0] RA_MACRO = 3'd4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_hold.sv
module gpio_addr_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ale,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] view
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)      hold_q <= '0;
    else if (ale) hold_q <= addr_in;
  end

  // Open while the enable is high, closed on the held copy otherwise.
  assign view = ale ? addr_in : hold_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W            = 8,
  parameter bit HAS_CTRL_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_sync,
  input  logic [W-1:0]      mc_out,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      ctrl_q,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      case (addr)
        RA_DOUT: dout_q <= wdata;
        RA_DIR:  dir_q  <= wdata;
        RA_CTRL: if (HAS_CTRL_SEL) ctrl_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      RA_PIN:   rd_mux = pin_sync;
      RA_DOUT:  rd_mux = dout_q;
      RA_DIR:   rd_mux = dir_q;
      RA_CTRL:  rd_mux = ctrl_q;
      RA_MACRO: rd_mux = mc_out;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  src_e sel,
  input  logic dout,
  input  logic lat,
  input  logic mc,
  input  logic cs,
  input  logic oe_from_mc,
  input  logic mc_oe,
  input  logic dir,
  output logic pad_out,
  output logic pad_oe
);
  logic nxt_out;

  always_comb begin
    case (sel)
      SRC_ADDR:  nxt_out = lat;
      SRC_MACRO: nxt_out = mc;
      SRC_CSEL:  nxt_out = cs;
      default:   nxt_out = dout;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= oe_from_mc ? mc_oe : dir;
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int W            = 8,
  parameter bit HAS_CTRL_SEL = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic              ale,
  input  logic [W-1:0]      addr_in,
  input  logic [W-1:0]      mc_out,
  input  logic [W-1:0]      mc_oe,
  input  logic [W-1:0]      cs_in,
  input  logic [2*W-1:0]    cfg_sel,
  input  logic [W-1:0]      cfg_oe_mc,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] lat_q;
  logic [W-1:0] dout_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] ctrl_q;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_addr_hold #(.W(W)) u_alat (
    .clk(clk), .rst(rst), .ale(ale), .addr_in(addr_in), .view(lat_q)
  );

  gpio_port_regs #(.W(W), .HAS_CTRL_SEL(HAS_CTRL_SEL)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pin_sync(pin_sync), .mc_out(mc_out),
    .dout_q(dout_q), .dir_q(dir_q), .ctrl_q(ctrl_q), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    src_e cfg_code;
    src_e eff_sel;
    assign cfg_code = src_e'(cfg_sel[2*i +: 2]);

    if (HAS_CTRL_SEL) begin : g_ctrl
      assign eff_sel = ctrl_q[i] ? cfg_code : SRC_DATA;
    end else begin : g_static
      assign eff_sel = cfg_code;
    end

    gpio_pin_drive u_pin (
      .clk(clk), .rst(rst), .sel(eff_sel),
      .dout(dout_q[i]), .lat(lat_q[i]), .mc(mc_out[i]), .cs(cs_in[i]),
      .oe_from_mc(cfg_oe_mc[i]), .mc_oe(mc_oe[i]), .dir(dir_q[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i])
    );
  end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic [W-1:0]      addr_in,
  input logic [W-1:0]      lat_q,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [W-1:0]      dout_q,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      ctrl_q,
  input logic [W-1:0]      reg_rdata,
  input logic [W-1:0]      mc_oe,
  input logic [W-1:0]      cfg_oe_mc,
  input logic [W-1:0]      pad_oe
);
  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
    ale |-> lat_q == addr_in);  // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ale && $past(!ale)) |-> $stable(lat_q));  // R5

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_we && (reg_addr == RA_PIN || reg_addr >= RA_MACRO)) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(ctrl_q)));  // R7

  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RA_DIR) |=> reg_rdata == $past(dir_q));  // R2

  AST_OE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(cfg_oe_mc) |=>
      pad_oe == $past((cfg_oe_mc & mc_oe) | (~cfg_oe_mc & dir_q)));  // R6
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .addr_in(addr_in), .lat_q(lat_q),
  .reg_we(reg_we), .reg_addr(reg_addr), .dout_q(dout_q), .dir_q(dir_q),
  .ctrl_q(ctrl_q), .reg_rdata(reg_rdata), .mc_oe(mc_oe),
  .cfg_oe_mc(cfg_oe_mc), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_mux_port.sv
`timescale 1ns/1ps
module tb_gpio_mux_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         ale = 1'b0;
  logic [W-1:0] addr_in = '0, mc_out = '0, mc_oe = '0, cs_in = '0;
  logic [2*W-1:0] cfg_sel = '0;
  logic [W-1:0] cfg_oe_mc = '0, pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_dout = '0, m_dir = '0, m_ctrl = '0;

  always #2.5 clk = ~clk;

  gpio_mux_port dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ale(ale),
    .addr_in(addr_in), .mc_out(mc_out), .mc_oe(mc_oe), .cs_in(cs_in),
    .cfg_sel(cfg_sel), .cfg_oe_mc(cfg_oe_mc), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
    case (a)
      3'd1: m_dout = d;
      3'd2: m_dir  = d;
      3'd3: m_ctrl = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    reg_addr = a;
    step(1);
    v = reg_rdata;
  endtask

  function automatic logic [W-1:0] exp_out(input logic [W-1:0] lat);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      logic [1:0] c;
      c = m_ctrl[i] ? cfg_sel[2*i +: 2] : 2'd0;
      case (c)
        2'd1: r[i] = lat[i];
        2'd2: r[i] = mc_out[i];
        2'd3: r[i] = cs_in[i];
        default: r[i] = m_dout[i];
      endcase
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_oe();
    return (cfg_oe_mc & mc_oe) | (~cfg_oe_mc & m_dir);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] a1;
    void'($urandom(32'h1a2b3c4d));
    step(3);
    rst = 1'b0;
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    rd(3'd1, v); chk("R1 dout", v, 8'h00);
    rd(3'd2, v); chk("R1 dir", v, 8'h00);
    rd(3'd3, v); chk("R1 ctrl", v, 8'h00);

    // R2 register write and readback
    wr(3'd1, 8'h3C); wr(3'd2, 8'hC5); wr(3'd3, 8'h00);
    rd(3'd1, v); chk("R2 dout", v, 8'h3C);
    rd(3'd2, v); chk("R2 dir", v, 8'hC5);
    chk("R4 data source", pad_out, 8'h3C);
    chk("R6 dir enable", pad_oe, 8'hC5);

    // R3 write to pin address ignored; R7 writes to 4..7 ignored
    wr(3'd0, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd1, v); chk("R3 dout kept", v, 8'h3C);
    rd(3'd2, v); chk("R7 dir kept", v, 8'hC5);
    rd(3'd3, v); chk("R7 ctrl kept", v, 8'h00);
    mc_out = 8'h96;
    rd(3'd4, v); chk("R7 macro readback", v, 8'h96);
    rd(3'd5, v); chk("R7 unmapped zero", v, 8'h00);

    // R3 synchronizer latency, R8 external level while driving
    wr(3'd2, 8'hFF); wr(3'd1, 8'h0F);
    reg_addr = 3'd0;
    step(4);
    pad_in = 8'hA5;
    step(2); chk("R3 not yet", reg_rdata, 8'h00);
    step(1); chk("R3 third edge", reg_rdata, 8'hA5);
    chk("R8 pin level while driving", reg_rdata, 8'hA5);

    // R5 address latch closing edge
    cfg_sel = {W{2'd1}}; wr(3'd3, 8'hFF);
    ale = 1'b1; addr_in = 8'h5A;
    step(1);
    chk("R5 open", pad_out, 8'h5A);
    ale = 1'b0; addr_in = 8'hE1;
    step(1); chk("R5 hold", pad_out, 8'h5A);
    step(2); chk("R5 still held", pad_out, 8'h5A);
    a1 = 8'h5A;

    // R4 R6 random per-pin configurations
    ale = 1'b1;
    for (int it = 0; it < 40; it++) begin
      cfg_sel   = 16'($urandom);
      cfg_oe_mc = 8'($urandom);
      mc_out    = 8'($urandom);
      mc_oe     = 8'($urandom);
      cs_in     = 8'($urandom);
      addr_in   = 8'($urandom);
      wr(3'd1, 8'($urandom));
      wr(3'd2, 8'($urandom));
      wr(3'd3, 8'($urandom));
      step(1);
      chk("R4 random source", pad_out, exp_out(addr_in));
      chk("R6 random enable", pad_oe, exp_oe());
      rd(3'd3, v); chk("R2 ctrl readback", v, m_ctrl);
    end
    ale = 1'b0;
    step(1);
    a1 = addr_in;
    addr_in = ~addr_in;
    step(2);
    chk("R5 held after random", pad_out, exp_out(a1));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule